// File: doc/BRIEF.md
# Fractional-Rate Strobe Generator

This block emits a strobe that is high for one clock cycle at an average rate of Fclk × M / N. M is the runtime step input and N is the modulus input. N can be any integer and need not be a power of two. When N is set equal to the clock frequency in hertz, M reads directly as the output frequency in hertz. Typical users are baud-rate ticks and periodic sampling enables. When the ratio N / M is not an integer, the strobe spacing alternates between neighbouring whole cycle counts. The average rate is still exact.

The core is a signed phase accumulator. When it is negative it adds N and nothing else, and the strobe fires on the next edge. On the cycle after that, it subtracts 2M to make up for the step it skipped. On every other cycle it subtracts M. A single adder sits in the feedback loop. Its second operand comes from a three-way select: N, the one's complement of M, or the one's complement of 2M. The subtracting cases take their +1 through the carry input. 2M is formed by wiring M one bit to the left. The scheme only holds while 2M ≤ N.

Top module: `frac_strobe_gen`

## Requirements
- R1: `pulse_o` is registered. After an edge it is 1 exactly when the accumulator was negative before that edge. The accumulator starts at 0. From reset at a constant M, the first strobe appears after the second active edge.
- R2: `pulse_o` is never high on two consecutive cycles, and the accumulator is non-negative in every cycle where `pulse_o` is high.
- R3: At constant M, the strobe sequence matches, cycle for cycle, a reference accumulator that starts at 0 and works as follows. It subtracts M each cycle. When it is negative it adds N − M instead and pulses on the next edge.
- R4: From reset, the number of strobes in C cycles lies within ±1 of floor(C × M / N).
- R5: With N = 50000 and M = 9600, the strobe count over 50000 cycles is 9600 ± 1, so M equals the rate per N cycles.
- R6: A new value on `rate_i` is used in the accumulator update at the very next active edge. With the accumulator at 0, changing M from 0 to a non-zero value gives a strobe after the second edge.
- R7: When M = 0 and the accumulator is non-negative, no strobe ever appears. After M is dropped to 0 while running, the strobes stop once the accumulator has recovered.
- R8: `rst_n` is asynchronous and active low. While it is low `pulse_o` is 0. After it is released the accumulator restarts from 0 and the R3 sequence starts over.
- R9: At the boundary M = N / 2, the strobe toggles every cycle from the second edge onward: exactly C / 2 strobes in C cycles for even C.
- R10: `rate_i` must satisfy 2 × M ≤ N while the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| modulus_i | input | MOD_W | Accumulator modulus N, held steady while running |
| rate_i | input | MOD_W-1 | Phase step M, at most N / 2 |
| pulse_o | output | 1 | One-cycle strobe, one per accumulator wrap |

## Verification
The in-line assertions check the following on every cycle:
- a negative accumulator always turns into a strobe on the next edge;
- a strobe is never followed by a second one;
- the accumulator is never negative while a strobe is high;
- a zero step cannot drive a non-negative accumulator below zero;
- the step input respects the half-modulus limit;
- the block leaves reset with the accumulator at 0.

Several behaviours can only be shown by the bench's scenarios:
- the exact strobe timing against the N − M reference model;
- the long-run average count for a non-power-of-two modulus;
- the M = N / 2 boundary;
- the one-edge latency of a step change;
- the draining after the step drops to zero.

// File: rtl/frac_strobe_pkg.sv
package frac_strobe_pkg;

  // Operand chosen for the single accumulator adder
  typedef enum logic [1:0] {
    OP_STEP   = 2'd0,   // subtract M
    OP_DOUBLE = 2'd1,   // subtract 2M, cycle after a wrap
    OP_WRAP   = 2'd2    // add N, step skipped
  } op_sel_e;

endpackage

// File: rtl/fs_op_select.sv
module fs_op_select
  import frac_strobe_pkg::*;
#(
  parameter int MOD_W  = 16,
  parameter int RATE_W = MOD_W - 1,
  parameter int ACC_W  = MOD_W + 1
) (
  input  logic              acc_neg,
  input  logic              post_wrap,
  input  logic [MOD_W-1:0]  modulus,
  input  logic [RATE_W-1:0] rate,
  output logic [ACC_W-1:0]  operand,
  output logic              carry_in
);

  localparam int MPAD = ACC_W - RATE_W;

  op_sel_e          sel;
  logic [ACC_W-1:0] mod_ext;
  logic [ACC_W-1:0] step_ext;
  logic [ACC_W-1:0] dbl_ext;

  // Wrap handling has priority over the make-up cycle
  always_comb begin
    if (acc_neg)        sel = OP_WRAP;
    else if (post_wrap) sel = OP_DOUBLE;
    else                sel = OP_STEP;
  end

  always_comb begin
    mod_ext  = {{(ACC_W-MOD_W){1'b0}}, modulus};
    step_ext = {{MPAD{1'b0}}, rate};
    dbl_ext  = {{(MPAD-1){1'b0}}, rate, 1'b0};
  end

  // Subtraction uses the one's complement plus carry-in, keeping one adder
  always_comb begin
    unique case (sel)
      OP_WRAP: begin
        operand  = mod_ext;
        carry_in = 1'b0;
      end
      OP_DOUBLE: begin
        operand  = ~dbl_ext;
        carry_in = 1'b1;
      end
      default: begin
        operand  = ~step_ext;
        carry_in = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fs_phase_acc.sv
module fs_phase_acc #(
  parameter int ACC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] operand,
  input  logic             carry_in,
  output logic [ACC_W-1:0] acc_q,
  output logic             acc_neg
);

  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  // Next state: the only adder in the loop
  always_comb begin
    acc_en = 1'b1;
    acc_d  = acc_q + operand + {{(ACC_W-1){1'b0}}, carry_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_neg = acc_q[ACC_W-1];

endmodule

// File: rtl/fs_wrap_flag.sv
module fs_wrap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_neg,
  output logic flag_q
);

  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = 1'b1;
    flag_d  = acc_neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

endmodule

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen #(
  parameter  int MOD_W  = 16,
  localparam int RATE_W = MOD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MOD_W-1:0]  modulus_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              pulse_o
);

  localparam int ACC_W = MOD_W + 1;

  logic [ACC_W-1:0] operand;
  logic             carry_in;
  logic [ACC_W-1:0] acc_q;
  logic             acc_neg;
  logic             post_wrap;

  fs_op_select #(.MOD_W(MOD_W), .RATE_W(RATE_W), .ACC_W(ACC_W)) sel_i (
    .acc_neg   (acc_neg),
    .post_wrap (post_wrap),
    .modulus   (modulus_i),
    .rate      (rate_i),
    .operand   (operand),
    .carry_in  (carry_in)
  );

  fs_phase_acc #(.ACC_W(ACC_W)) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .operand  (operand),
    .carry_in (carry_in),
    .acc_q    (acc_q),
    .acc_neg  (acc_neg)
  );

  fs_wrap_flag flag_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_neg (acc_neg),
    .flag_q  (post_wrap)
  );

  // The make-up flag doubles as the strobe
  assign pulse_o = post_wrap;

  // R1
  wrap_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_neg |=> pulse_o);

  // R2
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R2
  post_wrap_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> !acc_neg);

  // R7
  zero_rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_neg && rate_i == '0) |=> !acc_neg);

  // R10
  rate_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, rate_i, 1'b0} <= {1'b0, modulus_i});

  // R8
  reset_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pulse_o && acc_q == '0));

endmodule

// File: tb/frac_strobe_gen_tb_top.sv
module frac_strobe_gen_tb_top;

  localparam int MOD_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [MOD_W-1:0]  modulus_i = '0;
  logic [MOD_W-2:0]  rate_i = '0;
  logic              pulse_o;

  int errors = 0;
  int checks = 0;
  int n_mod = 10;
  int cur_rate = 0;
  int ref_acc = 0;
  bit sb_on = 1'b0;
  int pulse_cnt = 0;
  bit prev_pulse = 1'b0;
  bit exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  frac_strobe_gen #(.MOD_W(MOD_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .modulus_i (modulus_i),
    .rate_i    (rate_i),
    .pulse_o   (pulse_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: pops expected strobe values and compares, counts strobes
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (exp_q.size() > 0) begin
        bit e;
        e = exp_q.pop_front();
        check(pulse_o === e, "R3", int'(pulse_o), int'(e));
      end
      if (prev_pulse)
        check(!pulse_o, "R2", int'(pulse_o), 0);
      prev_pulse = pulse_o;
      if (pulse_o) pulse_cnt++;
    end
  end

  // Driver: called at a negedge, drives the step and queues the expected strobe
  task automatic drive_cycle();
    rate_i = cur_rate[MOD_W-2:0];
    if (sb_on) begin
      if (ref_acc < 0) begin
        ref_acc += n_mod - cur_rate;
        exp_q.push_back(1'b1);
      end else begin
        ref_acc -= cur_rate;
        exp_q.push_back(1'b0);
      end
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) drive_cycle();
  endtask

  task automatic do_reset(input int n, input int m);
    rst_n = 1'b0;
    n_mod = n;
    cur_rate = m;
    modulus_i = n[MOD_W-1:0];
    rate_i = m[MOD_W-2:0];
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(pulse_o === 1'b0, "R8", int'(pulse_o), 0);
    ref_acc = 0;
    pulse_cnt = 0;
    prev_pulse = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    int lo;
    @(negedge clk);

    // R1, R3: N=7, M=3, first strobe after second edge
    sb_on = 1'b1;
    do_reset(7, 3);
    drive_cycle();
    check(pulse_o === 1'b0, "R1", int'(pulse_o), 0);
    drive_cycle();
    check(pulse_o === 1'b1, "R1", int'(pulse_o), 1);
    run(60);

    // R9: M = N/2 boundary, 20 cycles give 10 strobes
    do_reset(10, 5);
    run(20);
    check(pulse_cnt == 10, "R9", pulse_cnt, 10);

    // R4: N=1000, M=333 over 3000 cycles
    do_reset(1000, 333);
    run(3000);
    lo = (3000 * 333) / 1000;
    check(pulse_cnt >= lo - 1 && pulse_cnt <= lo + 1, "R4", pulse_cnt, lo);

    // R8: reset mid-run restarts the sequence from zero
    do_reset(13, 4);
    run(7);
    do_reset(13, 4);
    drive_cycle();
    drive_cycle();
    check(pulse_o === 1'b1, "R8", int'(pulse_o), 1);
    run(40);

    // R7, R6: zero step holds, then new step used at the next edge
    do_reset(10, 0);
    run(5);
    check(pulse_cnt == 0, "R7", pulse_cnt, 0);
    cur_rate = 3;
    drive_cycle();
    check(pulse_o === 1'b0, "R6", int'(pulse_o), 0);
    drive_cycle();
    check(pulse_o === 1'b1, "R6", int'(pulse_o), 1);
    run(30);

    // R7: drop the step to zero while running, strobes drain then stop
    sb_on = 1'b0;
    do_reset(10, 4);
    run(23);
    cur_rate = 0;
    run(4);
    pulse_cnt = 0;
    run(50);
    check(pulse_cnt == 0, "R7", pulse_cnt, 0);

    // R5: non-power-of-two modulus equal to a clock rate
    sb_on = 1'b1;
    do_reset(50000, 9600);
    run(50000);
    check(pulse_cnt >= 9599 && pulse_cnt <= 9601, "R5", pulse_cnt, 9600);
    check(exp_q.size() <= 1, "R3", exp_q.size(), 0);

    done = 1'b1;
    report();
  end

endmodule